// File: doc/BRIEF.md
# Dual 90 kHz Time Reference

This block holds the decoder's timing reference in two 24-bit time counters. Both advance by one on every cycle in which a 90 kHz tick enable, derived elsewhere from the system clock, is high. Audio and video synchronization logic downstream compare their time stamps against these counters.

A CPU writes a new time value through a small register port. The value goes into the counter that is currently inactive, and that counter becomes the active one. The counter that was active keeps counting on the old time base. Stamps that still refer to the base in use before a discontinuity can therefore be compared against the "previous" output while new stamps use the "active" output. Both counter values and the active-select bit can be read back through the same register port.

Top module: `dual_timebase`

## Requirements
- R1: After reset both counters hold 0 and `activeSel` is 0, so `activeTime` and `prevTime` are 0.
- R2: With no load, a cycle with `tickEn` high advances both counters by one. A cycle with `tickEn` low leaves both unchanged. Results are visible after that clock edge.
- R3: A counter at 0xFFFFFF that is advanced becomes 0, with no other effect.
- R4: A write (`regWrEn` high) to address 0 loads `regWrData[23:0]` into the counter not selected by `activeSel` and toggles `activeSel`. Bits 31:24 of the write data are ignored. Both changes are visible after that clock edge.
- R5: On a load, the formerly active counter is not reloaded. It becomes `prevTime` and keeps counting: it advances if `tickEn` is high in the load cycle and on every later tick.
- R6: When a load and a tick fall in the same cycle, the loaded counter takes the written value exactly. The next tick advances it from that value.
- R7: `regRdData` is combinational from `regAddr`. Address 0 returns counter 0 and address 1 returns counter 1, both zero-extended. Address 2 returns `activeSel` in bit 0 with all other bits 0. Address 3 returns 0.
- R8: Writes to addresses 1, 2 and 3 change neither counter nor `activeSel`.
- R9: `activeTime` always equals counter `activeSel` and `prevTime` the other counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle 90 kHz advance enable |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for read and write |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| activeTime | output | 24 | Current time base value |
| prevTime | output | 24 | Previous time base value |
| activeSel | output | 1 | Index of the active counter |

## Verification
The properties assume that `tickEn`, `regWrEn`, `regAddr` and `regWrData` are known, two-valued levels sampled at the rising edge. They also assume that the write data and address are meaningful whenever `regWrEn` is high. No rate limit on ticks or loads is assumed, so loads can arrive back to back and coincide with ticks. The stimulus changes inputs only on the falling edge. It draws random ticks, addresses and data from a fixed seed, biased toward loads near 0xFFFFFF so that wraps occur often. Directed sequences cover a load together with a tick, consecutive loads, and writes to the non-load addresses.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

  localparam int NUM_BASES = 2;

  typedef enum logic [1:0] {
    RD_BASE0  = 2'd0,
    RD_BASE1  = 2'd1,
    RD_SELECT = 2'd2,
    RD_NONE   = 2'd3
  } rdCode_t;

  typedef struct packed {
    logic [NUM_BASES-1:0] load;
    logic                 tick;
    rdCode_t              rd;
  } ctrlStrobes_t;

endpackage

// File: rtl/timebase_ctrl.sv
module timebase_ctrl
  import timebase_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobes_t      strobes,
  output logic              activeSel
);

  localparam logic [ADDR_W-1:0] ADDR_LOAD = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_B1   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_SEL  = ADDR_W'(2);

  logic loadHit;
  logic selQ;

  assign loadHit = regWrEn && (regAddr == ADDR_LOAD);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= 1'b0;
    end else if (loadHit) begin
      selQ <= ~selQ;
    end
  end

  assign activeSel = selQ;

  for (genvar g = 0; g < NUM_BASES; g++) begin : gLoad
    assign strobes.load[g] = loadHit && (selQ != 1'(g));
  end

  assign strobes.tick = tickEn;

  always_comb begin
    unique case (regAddr)
      ADDR_LOAD: strobes.rd = RD_BASE0;
      ADDR_B1:   strobes.rd = RD_BASE1;
      ADDR_SEL:  strobes.rd = RD_SELECT;
      default:   strobes.rd = RD_NONE;
    endcase
  end

endmodule

// File: rtl/timebase_datapath.sv
module timebase_datapath
  import timebase_pkg::*;
#(
  parameter int TIME_W = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic              activeSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [TIME_W-1:0] activeTime,
  output logic [TIME_W-1:0] prevTime
);

  localparam int PAD_W = DATA_W - TIME_W;

  logic [TIME_W-1:0] cntVal [NUM_BASES];

  for (genvar g = 0; g < NUM_BASES; g++) begin : gBase
    logic [TIME_W-1:0] cntQ;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (strobes.load[g]) begin
        cntQ <= regWrData[TIME_W-1:0];
      end else if (strobes.tick) begin
        cntQ <= cntQ + 1'b1;
      end
    end
    assign cntVal[g] = cntQ;
  end

  assign activeTime = activeSel ? cntVal[1] : cntVal[0];
  assign prevTime   = activeSel ? cntVal[0] : cntVal[1];

  always_comb begin
    unique case (strobes.rd)
      RD_BASE0:  regRdData = {{PAD_W{1'b0}}, cntVal[0]};
      RD_BASE1:  regRdData = {{PAD_W{1'b0}}, cntVal[1]};
      RD_SELECT: regRdData = {{(DATA_W-1){1'b0}}, activeSel};
      default:   regRdData = '0;
    endcase
  end

endmodule

// File: rtl/dual_timebase.sv
module dual_timebase
  import timebase_pkg::*;
#(
  parameter int TIME_W = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [TIME_W-1:0] activeTime,
  output logic [TIME_W-1:0] prevTime,
  output logic              activeSel
);

  ctrlStrobes_t strobes;

  timebase_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn),
    .regAddr(regAddr), .strobes(strobes), .activeSel(activeSel)
  );

  timebase_datapath #(.TIME_W(TIME_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .activeSel(activeSel),
    .regWrData(regWrData), .regRdData(regRdData),
    .activeTime(activeTime), .prevTime(prevTime)
  );

endmodule

// File: rtl/timebase_checker.sv
module timebase_checker #(
  parameter int TIME_W = 24,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic [TIME_W-1:0] activeTime,
  input logic [TIME_W-1:0] prevTime,
  input logic              activeSel
);

  logic isLoad;
  assign isLoad = regWrEn && (regAddr == '0);

  // R2: advance by one on a tick
  assert_tick_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!isLoad && tickEn) |=> (activeTime == TIME_W'($past(activeTime) + 1'b1))
                         && (prevTime == TIME_W'($past(prevTime) + 1'b1)));

  // R2, R8: hold without tick or load
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!isLoad && !tickEn) |=> $stable(activeTime) && $stable(prevTime) && $stable(activeSel));

  // R3: wrap to zero
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!isLoad && tickEn && (activeTime == '1)) |=> (activeTime == '0));

  // R4, R6: load value and select flip
  assert_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    isLoad |=> (activeTime == $past(regWrData[TIME_W-1:0])) && (activeSel != $past(activeSel)));

  // R5: old active keeps counting as previous
  assert_prev_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
    isLoad |=> (prevTime == TIME_W'($past(activeTime) + TIME_W'($past(tickEn)))));

  // R7: select readback
  assert_read_sel_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2) |-> (regRdData == {{(DATA_W-1){1'b0}}, activeSel}));

  // R9: counter readback agrees with the active output
  assert_active_view_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(activeSel)) |-> (regRdData[TIME_W-1:0] == activeTime));

endmodule

bind dual_timebase timebase_checker #(.TIME_W(TIME_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .activeTime(activeTime),
  .prevTime(prevTime), .activeSel(activeSel)
);

// File: tb/tb_dual_timebase.sv
module tb_dual_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 24;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0;
  logic [DW-1:0] regRdData;
  logic [TW-1:0] activeTime, prevTime;
  logic activeSel;

  int checks = 0, fails = 0;
  logic [TW-1:0] m0 = '0, m1 = '0;
  logic mSel = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_timebase dut (.*);

  function automatic logic [DW-1:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return {8'h0, m0};
      2'd1: return {8'h0, m1};
      2'd2: return {31'h0, mSel};
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(input string req);
    check({req, " activeTime R9"}, DW'(activeTime), DW'(mSel ? m1 : m0));
    check({req, " prevTime R9"}, DW'(prevTime), DW'(mSel ? m0 : m1));
    check({req, " activeSel"}, DW'(activeSel), DW'(mSel));
    check({req, " readback R7"}, regRdData, expRead(regAddr));
  endtask

  // drive at negedge, clock, update model, check at next negedge
  task automatic step(input logic t, input logic w, input logic [1:0] a,
                      input logic [DW-1:0] d, input string req);
    regTickDrive(t, w, a, d);
    @(posedge clk);
    if (w && a == 2'd0) begin
      if (mSel) begin m0 = d[TW-1:0]; m1 = m1 + TW'(t); end
      else      begin m1 = d[TW-1:0]; m0 = m0 + TW'(t); end
      mSel = ~mSel;
    end else if (t) begin
      m0 = m0 + 1'b1; m1 = m1 + 1'b1;
    end
    @(negedge clk);
    checkAll(req);
  endtask

  task automatic regTickDrive(input logic t, input logic w, input logic [1:0] a, input logic [DW-1:0] d);
    tickEn = t; regWrEn = w; regAddr = a; regWrData = d;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      regAddr = 2'(a); #1;
      checkAll("R1");
    end
    // R2 ticks and idle
    step(1, 0, 2'd0, 0, "R2 tick");
    step(0, 0, 2'd1, 0, "R2 idle");
    step(1, 0, 2'd2, 0, "R2 tick");
    // R4 load with junk upper byte, R5 previous keeps counting
    step(0, 1, 2'd0, 32'hAB12_3456, "R4 load");
    step(1, 0, 2'd1, 0, "R5 prev tick");
    // R6 load together with tick, then tick
    step(1, 1, 2'd0, 32'h00FF_FFFE, "R6 load+tick");
    step(1, 0, 2'd0, 0, "R6 next tick");
    // R3 wrap
    step(1, 0, 2'd0, 0, "R3 wrap");
    step(1, 0, 2'd3, 0, "R3 after wrap");
    // R8 writes to other addresses ignored
    step(0, 1, 2'd1, 32'h0012_3456, "R8 addr1");
    step(1, 1, 2'd2, 32'hFFFF_FFFF, "R8 addr2");
    step(0, 1, 2'd3, 32'h0055_5555, "R8 addr3");
    // back-to-back loads, R4
    step(0, 1, 2'd0, 32'h0000_0010, "R4 b2b");
    step(1, 1, 2'd0, 32'h0000_0020, "R4 b2b");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      logic [DW-1:0] d;
      r = $urandom;
      d = (r[7:5] == 3'd0) ? (32'h00FF_FFF0 | 32'(r[11:8])) : $urandom;
      step(r[0] | r[1], r[4:2] == 3'd0, r[13:12], d, "R2 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule